// File: doc/BRIEF.md
# Lockable Debug Monitor Memory

This block is an on-chip memory that sits on the processor bus and holds a debug monitor program. At start-up, boot software writes the monitor image into the code window through the normal bus slave port. It may then set a one-shot lock. Once the lock is set, the code window accepts no further changes, so errant software cannot overwrite the monitor. Setting the lock is optional.

A second, smaller scratch window holds the monitor's stack and variables. It stays writable whether the lock is set or not. Only a full reset clears the lock, and no bus write can undo it. A control word reports the lock state and is the only way to set it.

The word address map is as follows. Word addresses 0x000–0x7FF are code, 0x800–0x9FF are scratch, and 0xA00–0xBFF are unmapped. Any address with the top two bits equal to 2'b11 (0xC00–0xFFF) selects the control word.

Top module: `dbg_stub_mem`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `ack` is low. Right after reset, a read of the control word returns 0.
- R2: Each request (`cyc` and `stb` high while `ack` is low) gets exactly one `ack` pulse, one cycle later, and `ack` is low on the following cycle. Read data is valid on `dat_r` while `ack` is high.
- R3: While the lock is clear, a write to the code window updates only the bytes whose `sel` bit is set (`sel[i]` covers `dat_w[8i+7:8i]`). A later read returns the merged word.
- R4: A write to the control word with `sel[0]` high and `dat_w[0]` high sets the lock. A control write with `dat_w[0]` low, or with `sel[0]` low, leaves the lock unchanged.
- R5: While the lock is set, a write to the code window is acknowledged like any other write, but the stored word is unchanged.
- R6: Once set, the lock stays set until `rst`. After a reset, the code window is writable again.
- R7: The scratch window takes byte-lane writes, with the same lane mapping as R3, whether the lock is set or not.
- R8: A read of the control word returns the lock state in bit 0 and zeros in bits 31:1.
- R9: A read in the unmapped range returns 0. A write there is acknowledged and changes no stored word and not the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| cyc | input | 1 | Bus cycle in progress |
| stb | input | 1 | Request strobe |
| we | input | 1 | 1 = write, 0 = read |
| adr | input | 12 | Word address |
| sel | input | 4 | Byte-lane enables for writes |
| dat_w | input | 32 | Write data |
| dat_r | output | 32 | Read data, valid with ack |
| ack | output | 1 | One-cycle acknowledge |

## Verification
A lock flop that sets by mistake shows up as soon as the next code write fails to change the stored word. A lock flop that clears by mistake shows up on the next control-word read, one cycle after that request. A wrong byte-lane merge or wrong window decoding shows in the read data of the next access to the affected word. The bench fills every word, so no stale or unknown value can hide such an error. An acknowledge that is missing, late or doubled is visible on the cycle after the request and the cycle after that.

// File: rtl/dbg_stub_mem.sv
module dbg_stub_mem #(
  parameter int CODE_AW = 11,
  parameter int SCR_AW  = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc,
  input  logic                 stb,
  input  logic                 we,
  input  logic [CODE_AW:0]     adr,
  input  logic [3:0]           sel,
  input  logic [31:0]          dat_w,
  output logic [31:0]          dat_r,
  output logic                 ack
);
  localparam int AW     = CODE_AW + 1;
  localparam int CODE_N = 1 << CODE_AW;
  localparam int SCR_N  = 1 << SCR_AW;

  logic [31:0] code_mem [CODE_N];
  logic [31:0] scr_mem  [SCR_N];
  logic        locked;

  wire req     = cyc & stb & ~ack;
  wire in_code = ~adr[AW-1];
  wire in_scr  = (adr[AW-1:AW-2] == 2'b10) && (adr[AW-3:SCR_AW] == '0);
  wire in_ctl  = (adr[AW-1:AW-2] == 2'b11);
  wire code_wr = req & we & in_code & ~locked;
  wire scr_wr  = req & we & in_scr;
  wire lock_wr = req & we & in_ctl & sel[0] & dat_w[0];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (code_wr && sel[i]) code_mem[adr[CODE_AW-1:0]][8*i +: 8] <= dat_w[8*i +: 8];
      if (scr_wr && sel[i])  scr_mem[adr[SCR_AW-1:0]][8*i +: 8]   <= dat_w[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (req && !we) begin
      if (in_code)     dat_r <= code_mem[adr[CODE_AW-1:0]];
      else if (in_scr) dat_r <= scr_mem[adr[SCR_AW-1:0]];
      else if (in_ctl) dat_r <= {31'b0, locked};
      else             dat_r <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack    <= 1'b0;
      locked <= 1'b0;
    end else begin
      ack <= req;
      if (lock_wr) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_stub_mem_chk.sv
module dbg_stub_mem_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc,
  input logic          stb,
  input logic          we,
  input logic [AW-1:0] adr,
  input logic [3:0]    sel,
  input logic [31:0]   dat_w,
  input logic          ack,
  input logic          locked
);
  wire req = cyc & stb & ~ack;

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);

  // R2
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R2
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(cyc && stb) |=> !ack);

  // R4
  lock_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (req && we && adr[AW-1:AW-2] == 2'b11 && sel[0] && dat_w[0]) |=> locked);

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R4
  lock_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(req && we && sel[0] && dat_w[0]));
endmodule

bind dbg_stub_mem dbg_stub_mem_chk #(.AW(CODE_AW + 1)) u_chk (
  .clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
  .sel(sel), .dat_w(dat_w), .ack(ack), .locked(locked)
);

// File: tb/tb_dbg_stub_mem.sv
`timescale 1ns/1ps
module tb_dbg_stub_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [11:0] adr = '0;
  logic [3:0]  sel = '0;
  logic [31:0] dat_w = '0;
  logic [31:0] dat_r;
  logic        ack;

  int compared = 0, mismatched = 0;
  logic [31:0] code_m [2048];
  logic [31:0] scr_m  [512];
  bit lk = 0;

  always #2 clk = ~clk;

  dbg_stub_mem dut (.clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we),
    .adr(adr), .sel(sel), .dat_w(dat_w), .dat_r(dat_r), .ack(ack));

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (s[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expect_rd(logic [11:0] a);
    if (!a[11])              return code_m[a[10:0]];
    if (a[11:9] == 3'b100)   return scr_m[a[8:0]];
    if (a[11:10] == 2'b11)   return {31'b0, lk};
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input bit w, input logic [11:0] a, input logic [3:0] s,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; sel = s; dat_w = d;
    @(negedge clk);
    check("R2 ack high", {31'b0, ack}, 32'd1);
    rd = dat_r;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check("R2 ack low", {31'b0, ack}, 32'd0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] s, input logic [31:0] d);
    logic [31:0] rd;
    bus(1, a, s, d, rd);
    if (!a[11]) begin
      if (!lk) code_m[a[10:0]] = merge(code_m[a[10:0]], d, s);
    end else if (a[11:9] == 3'b100) scr_m[a[8:0]] = merge(scr_m[a[8:0]], d, s);
    else if (a[11:10] == 2'b11 && s[0] && d[0]) lk = 1;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a);
    logic [31:0] r;
    bus(0, a, 4'h0, 32'h0, r);
    check(tag, r, expect_rd(a));
  endtask

  function automatic logic [11:0] rnd_adr(bit allow_ctl);
    int k = $urandom % 4;
    case (k)
      0: return {1'b0, 11'($urandom)};
      1: return {3'b100, 9'($urandom)};
      2: return allow_ctl ? {2'b11, 10'($urandom)} : {1'b0, 11'($urandom)};
      default: return {3'b101, 9'($urandom)};
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (!a[11]) return lk ? "R5 locked code" : "R3 code";
    if (a[11:9] == 3'b100) return "R7 scratch";
    if (a[11:10] == 2'b11) return "R8 ctrl";
    return "R9 unmapped";
  endfunction

  task automatic random_phase(int n, bit allow_ctl);
    for (int i = 0; i < n; i++) begin
      logic [11:0] a = rnd_adr(allow_ctl);
      if ($urandom % 2) wr(a, 4'($urandom), $urandom);
      else rd_chk(tag_of(a), a);
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 ack in reset", {31'b0, ack}, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R1 ack after reset", {31'b0, ack}, 32'd0);
    rd_chk("R1 lock clear", 12'hC00);

    for (int i = 0; i < 2048; i++) wr(12'(i), 4'hF, $urandom);
    for (int i = 0; i < 512; i++)  wr(12'h800 + 12'(i), 4'hF, $urandom);

    wr(12'h005, 4'hF, 32'h1122_3344);
    wr(12'h005, 4'b0101, 32'hAABB_CCDD);
    rd_chk("R3 byte lanes", 12'h005);
    check("R3 merge value", expect_rd(12'h005), 32'h11BB_33DD);

    wr(12'hA10, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped read", 12'hA10);
    rd_chk("R9 unmapped no lock", 12'hC00);

    random_phase(600, 0);

    wr(12'hC00, 4'hF, 32'h0000_0000);
    rd_chk("R4 zero write no lock", 12'hC00);
    wr(12'hC00, 4'b1110, 32'hFFFF_FFFF);
    rd_chk("R4 sel0 low no lock", 12'hC00);
    wr(12'hC00, 4'b0001, 32'h0000_0001);
    check("R4 model locked", {31'b0, lk}, 32'd1);
    rd_chk("R4 R8 lock reads one", 12'hFFF);

    r = code_m[5];
    wr(12'h005, 4'hF, 32'hDEAD_BEEF);
    rd_chk("R5 locked write ignored", 12'h005);
    check("R5 value kept", expect_rd(12'h005), r);
    wr(12'h900, 4'b0011, 32'h1234_5678);
    rd_chk("R7 scratch while locked", 12'h900);
    wr(12'hC00, 4'hF, 32'h0);
    rd_chk("R6 lock sticky", 12'hC00);

    random_phase(600, 1);

    @(negedge clk); rst = 1; lk = 0;
    @(negedge clk); @(negedge clk);
    check("R1 ack during reset", {31'b0, ack}, 32'd0);
    rst = 0;
    rd_chk("R6 reset clears lock", 12'hC00);
    wr(12'h7FF, 4'hF, 32'hCAFE_F00D);
    rd_chk("R6 code writable after reset", 12'h7FF);
    check("R6 value", expect_rd(12'h7FF), 32'hCAFE_F00D);

    random_phase(300, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule